// File: doc/BRIEF.md
# NAND Command Phase Sequencer

This block runs a single NAND flash transaction from a set of fields prepared before a start pulse. A transaction is built from up to four phases: a first command byte, one to five address bytes, a data phase that reads or writes a given number of bytes, and a second command byte. Each phase has its own enable. The block drives chip enable, command latch, address latch, the write and read strobes and an 8-bit I/O bus. After a second command byte it watches the ready/busy line, and it raises an end flag when the transaction is over.

The address bytes come from one of three sources. The first is a raw 32-bit word plus an 8-bit extension byte. The second is a packer that builds the bytes from a column and a page number, using either the small-page or the large-page layout. The third is sector-access mode, in which the address word is the page number shifted left by two and the data length is one or four sectors. Write data arrives on a valid/ready stream. The block asserts `wr_ready` only when it can start a write strobe at once, and a byte moves on a cycle where `wr_valid` and `wr_ready` are both high. Read data leaves on a valid/ready stream. Once `rd_valid` is high, it and `rd_data` hold until `rd_ready` takes the byte, and no further read strobe is issued until then. This lets a slow consumer stall the flash bus without losing data.

Top module: `nand_phase_seq`

## Requirements
- R1: Phases run in a fixed order and each disabled phase is skipped. The order is the first command, then the address, and then either the data phase followed by the second command and busy wait (write or no data), or the second command and busy wait followed by the data phase (read). A data phase whose length is zero counts as disabled.
- R2: Command bytes are driven with `nand_cle` high. The first command is `cmd_word[7:0]` and the second is `cmd_word[15:8]`. All setup fields are captured at start, and later changes to the inputs have no effect on a running transaction.
- R3: Address bytes are driven with `nand_ale` high, lowest byte first: word bits 7:0, 15:8, 23:16 and 31:24, then the extension byte as the fifth byte. The number of bytes is `addr_cnt`, where 0 counts as 1 and 6 or 7 count as 5.
- R4: With packing enabled and `large_page`=1, the word is {page[15:8], page[7:0], 4'b0, column[11:0]} and the extension byte is page[23:16].
- R5: With packing enabled and `large_page`=0, the word is {page[23:16], page[15:8], page[7:0], column[7:0]} and the extension byte is 0.
- R6: When `bus16`=1 the column is halved before packing, unless `id_read`=1, in which case the column is used unchanged.
- R7: With `sector_mode`=1 the word is page shifted left by 2 and the extension byte is 0. The data length is 4×SECTOR_BYTES when `sector_four`=1 and SECTOR_BYTES otherwise, and `byte_count` is ignored.
- R8: Each write byte is taken only on a `wr_valid`&&`wr_ready` cycle and produces exactly one `nand_we_n` pulse, with the byte on `nand_io_out` and `nand_io_oe` high. No data strobe starts while `wr_valid` is low.
- R9: Each read byte takes one `nand_re_n` pulse. `nand_io_in` is sampled in the last low cycle of the pulse. `rd_valid` and `rd_data` hold until `rd_ready`, and no read strobe starts while a byte is waiting.
- R10: Each strobe stays low for STROBE_LOW cycles and high for STROBE_HIGH cycles. `nand_cle` and `nand_ale` are never high together, the two strobes are never low together, and `nand_io_oe` is low while `nand_re_n` is low.
- R11: After the second command the block waits for the synchronized `nand_rb_n` to go low and then high before it moves on. `busy` stays high and `end_flag` stays low until then.
- R12: If the busy wait lasts `wait_limit` cycles, `timeout_err` is set and the transaction ends with `end_flag` set.
- R13: `end_flag` and `timeout_err` stay set until a `clr_end` pulse, and `start` has no effect while `busy` is high.
- R14: `nand_ce_n` is low exactly while `busy` is high. At rest all strobes are high and `nand_cle`, `nand_ale` and `nand_io_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse; captures the setup fields |
| clr_end | input | 1 | Clears end_flag and timeout_err |
| cmd_word | input | 16 | [7:0] first command, [15:8] second command |
| en_cmd1 | input | 1 | Enables the first command phase |
| en_addr | input | 1 | Enables the address phase |
| en_cmd2 | input | 1 | Enables the second command and busy wait |
| en_data | input | 1 | Enables the data phase |
| dir_write | input | 1 | Data direction: 1 write, 0 read |
| addr_cnt | input | 3 | Number of address bytes (clamped to 1..5) |
| addr_pack | input | 1 | 1: packed column/page, 0: raw word |
| addr_raw | input | 32 | Raw address word |
| addr_ext_raw | input | 8 | Raw fifth address byte |
| col_num | input | 12 | Column number for packing |
| page_num | input | 24 | Page number for packing and sector mode |
| large_page | input | 1 | Selects the large-page layout |
| bus16 | input | 1 | 16-bit device bus; halves the column |
| id_read | input | 1 | ID read; column is not halved |
| sector_mode | input | 1 | Sector-access mode |
| sector_four | input | 1 | Four sectors instead of one |
| byte_count | input | 16 | Data length outside sector mode |
| wait_limit | input | 16 | Busy-wait timeout in cycles |
| wr_data | input | 8 | Write stream data |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| rd_data | output | 8 | Read stream data |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Read stream ready |
| busy | output | 1 | Transaction in progress |
| end_flag | output | 1 | Transaction finished |
| timeout_err | output | 1 | Busy wait timed out |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | I/O bus value driven out |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_in | input | 8 | I/O bus value read in |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
Some rules must hold on every cycle, and the checker tests these continuously. They are the mutual exclusion of the latch enables and of the two strobes, bus release during reads, and the link between chip enable and busy. They also cover stability of a stalled read byte and the rule that a data write strobe follows a stream handshake and a read strobe starts only with an empty read slot. The end flag rising only as a transaction closes, and a timeout being followed by the end flag, are checked the same way. What only the directed scenarios can show is whether the right bytes appear in the right order. That covers the phase order for reads versus writes, the large-page, small-page, halved-column, ID-read and sector layouts, the clamping of the address count, the sector data length, and the busy wait holding the end flag back until ready/busy returns high.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_LAUNCH, PH_CMD1, PH_ADDR, PH_DATA,
    PH_CMD2, PH_WLO, PH_WHI, PH_FIN
  } phase_t;

  localparam int COL_W      = 12;
  localparam int PAGE_W     = 24;
  localparam int ADDR_MAX   = 5;
  localparam int ABYTES_W   = 8 * ADDR_MAX;
endpackage

// File: rtl/nseq_addr_pack.sv
module nseq_addr_pack
  import nseq_pkg::*;
(
  input  logic              addr_pack,
  input  logic [31:0]       addr_raw,
  input  logic [7:0]        addr_ext_raw,
  input  logic [COL_W-1:0]  col_num,
  input  logic [PAGE_W-1:0] page_num,
  input  logic              large_page,
  input  logic              bus16,
  input  logic              id_read,
  input  logic              sector_mode,
  output logic [31:0]       addr_word,
  output logic [7:0]        addr_ext
);
  logic [COL_W-1:0] col_eff;

  always_comb begin
    // 16-bit devices address columns in words; ID reads stay byte-wide
    col_eff = (bus16 && !id_read) ? {1'b0, col_num[COL_W-1:1]} : col_num;
    if (sector_mode) begin
      addr_word = 32'({page_num, 2'b00});
      addr_ext  = 8'h00;
    end else if (!addr_pack) begin
      addr_word = addr_raw;
      addr_ext  = addr_ext_raw;
    end else if (large_page) begin
      addr_word = {page_num[15:8], page_num[7:0], 4'b0000, col_eff};
      addr_ext  = page_num[23:16];
    end else begin
      addr_word = {page_num[23:16], page_num[15:8], page_num[7:0], col_eff[7:0]};
      addr_ext  = 8'h00;
    end
  end
endmodule

// File: rtl/nseq_strobe.sv
module nseq_strobe #(
  parameter int LOW  = 2,
  parameter int HIGH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic active,
  output logic strobe_n,
  output logic sample,
  output logic done
);
  localparam int TOT = LOW + HIGH;
  localparam int CW  = (TOT > 1) ? $clog2(TOT) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (go) begin
        active <= 1'b1;
        cnt    <= '0;
      end
    end else if (cnt == CW'(TOT - 1)) begin
      active <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign strobe_n = !(active && (cnt < CW'(LOW)));
  assign sample   = active && (cnt == CW'(LOW - 1));
  assign done     = active && (cnt == CW'(TOT - 1));
endmodule

// File: rtl/nseq_ctrl.sv
module nseq_ctrl
  import nseq_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int WAIT_W       = 16,
  parameter int SECTOR_BYTES = 512,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clr_end,
  input  logic [15:0]       cmd_word,
  input  logic              en_cmd1,
  input  logic              en_addr,
  input  logic              en_cmd2,
  input  logic              en_data,
  input  logic              dir_write,
  input  logic [2:0]        addr_cnt,
  input  logic [31:0]       addr_word,
  input  logic [7:0]        addr_ext,
  input  logic              sector_mode,
  input  logic              sector_four,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [WAIT_W-1:0] wait_limit,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              busy,
  output logic              end_flag,
  output logic              timeout_err,
  input  logic              st_active,
  input  logic              st_sample,
  input  logic              st_done,
  output logic              st_go,
  output logic              rd_phase,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic [7:0]        nand_io_out,
  output logic              nand_io_oe,
  input  logic [7:0]        nand_io_in,
  input  logic              nand_rb_n
);
  localparam logic [CNT_W-1:0] ONE_SECTOR  = CNT_W'(SECTOR_BYTES);
  localparam logic [CNT_W-1:0] FOUR_SECTOR = CNT_W'(4 * SECTOR_BYTES);

  phase_t                state;
  logic [15:0]           cmd_q;
  logic                  f_cmd1, f_addr, f_cmd2, f_wr, f_data;
  logic [ABYTES_W-1:0]   abytes_q;
  logic [2:0]            nadr_q;
  logic [2:0]            aidx;
  logic [CNT_W-1:0]      remain;
  logic [WAIT_W-1:0]     wlim_q;
  logic [WAIT_W-1:0]     wcnt;
  logic [7:0]            wbyte;
  logic [SYNC_STAGES-1:0] rb_pipe;
  logic                  rb_s;

  // start-time values, derived from the inputs
  logic [CNT_W-1:0]      len_in;
  logic [2:0]            nadr_in;

  // phase successors, derived from the captured flags
  logic                  rd_mode;
  phase_t                nx_after_data, nx_after_addr, nx_after_cmd1, nx_after_wait;

  always_comb begin
    len_in  = sector_mode ? (sector_four ? FOUR_SECTOR : ONE_SECTOR) : byte_count;
    if (addr_cnt == 3'd0)      nadr_in = 3'd1;
    else if (addr_cnt > 3'd5)  nadr_in = 3'd5;
    else                       nadr_in = addr_cnt;
  end

  always_comb begin
    rd_mode       = f_data && !f_wr;
    nx_after_data = (!rd_mode && f_cmd2) ? PH_CMD2 : PH_FIN;
    if (rd_mode)      nx_after_addr = f_cmd2 ? PH_CMD2 : PH_DATA;
    else if (f_data)  nx_after_addr = PH_DATA;
    else              nx_after_addr = nx_after_data;
    nx_after_cmd1 = f_addr ? PH_ADDR : nx_after_addr;
    nx_after_wait = rd_mode ? PH_DATA : PH_FIN;
  end

  // ready/busy synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rb_pipe <= '1;
    else        rb_pipe <= {rb_pipe[SYNC_STAGES-2:0], nand_rb_n};
  end
  assign rb_s = rb_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= PH_IDLE;
      cmd_q       <= '0;
      f_cmd1      <= 1'b0;
      f_addr      <= 1'b0;
      f_cmd2      <= 1'b0;
      f_wr        <= 1'b0;
      f_data      <= 1'b0;
      abytes_q    <= '0;
      nadr_q      <= 3'd1;
      aidx        <= '0;
      remain      <= '0;
      wlim_q      <= '0;
      wcnt        <= '0;
      wbyte       <= '0;
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      end_flag    <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      if (clr_end) begin
        end_flag    <= 1'b0;
        timeout_err <= 1'b0;
      end
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (rd_phase && st_sample) begin
        rd_data  <= nand_io_in;
        rd_valid <= 1'b1;
      end
      if (wr_valid && wr_ready) wbyte <= wr_data;

      unique case (state)
        PH_IDLE: if (start) begin
          cmd_q    <= cmd_word;
          f_cmd1   <= en_cmd1;
          f_addr   <= en_addr;
          f_cmd2   <= en_cmd2;
          f_wr     <= dir_write;
          f_data   <= en_data && (len_in != '0);
          abytes_q <= {addr_ext, addr_word};
          nadr_q   <= nadr_in;
          aidx     <= '0;
          remain   <= len_in;
          wlim_q   <= wait_limit;
          state    <= PH_LAUNCH;
        end
        PH_LAUNCH: state <= f_cmd1 ? PH_CMD1 : nx_after_cmd1;
        PH_CMD1: if (st_done) state <= nx_after_cmd1;
        PH_ADDR: if (st_done) begin
          if (aidx == nadr_q - 3'd1) state <= nx_after_addr;
          else                       aidx  <= aidx + 3'd1;
        end
        PH_DATA: if (st_done) begin
          remain <= remain - 1'b1;
          if (remain == CNT_W'(1)) state <= nx_after_data;
        end
        PH_CMD2: if (st_done) begin
          wcnt  <= '0;
          state <= PH_WLO;
        end
        PH_WLO, PH_WHI: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == wlim_q) begin
            timeout_err <= 1'b1;
            state       <= PH_FIN;
          end else if (state == PH_WLO) begin
            if (!rb_s) state <= PH_WHI;
          end else if (rb_s) begin
            state <= nx_after_wait;
          end
        end
        PH_FIN: begin
          end_flag <= 1'b1;
          state    <= PH_IDLE;
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != PH_IDLE);
    nand_ce_n = !busy;
    nand_cle  = (state == PH_CMD1) || (state == PH_CMD2);
    nand_ale  = (state == PH_ADDR);
    rd_phase  = (state == PH_DATA) && !f_wr;
    wr_ready  = (state == PH_DATA) && f_wr && !st_active;
    nand_io_oe = nand_cle || nand_ale || ((state == PH_DATA) && f_wr);
    unique case (state)
      PH_CMD1: nand_io_out = cmd_q[7:0];
      PH_CMD2: nand_io_out = cmd_q[15:8];
      PH_ADDR: nand_io_out = abytes_q[{aidx, 3'b000} +: 8];
      PH_DATA: nand_io_out = f_wr ? wbyte : 8'h00;
      default: nand_io_out = 8'h00;
    endcase
    if (nand_cle || nand_ale) st_go = !st_active;
    else if (state == PH_DATA) st_go = f_wr ? (wr_valid && wr_ready)
                                            : (!st_active && !rd_valid);
    else st_go = 1'b0;
  end
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nseq_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int WAIT_W       = 16,
  parameter int SECTOR_BYTES = 512,
  parameter int STROBE_LOW   = 2,
  parameter int STROBE_HIGH  = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clr_end,
  input  logic [15:0]       cmd_word,
  input  logic              en_cmd1,
  input  logic              en_addr,
  input  logic              en_cmd2,
  input  logic              en_data,
  input  logic              dir_write,
  input  logic [2:0]        addr_cnt,
  input  logic              addr_pack,
  input  logic [31:0]       addr_raw,
  input  logic [7:0]        addr_ext_raw,
  input  logic [11:0]       col_num,
  input  logic [23:0]       page_num,
  input  logic              large_page,
  input  logic              bus16,
  input  logic              id_read,
  input  logic              sector_mode,
  input  logic              sector_four,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [WAIT_W-1:0] wait_limit,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              busy,
  output logic              end_flag,
  output logic              timeout_err,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_io_out,
  output logic              nand_io_oe,
  input  logic [7:0]        nand_io_in,
  input  logic              nand_rb_n
);
  logic [31:0] pk_word;
  logic [7:0]  pk_ext;
  logic        st_go, st_active, st_strobe_n, st_sample, st_done, rd_phase;

  nseq_addr_pack u_pack (
    .addr_pack    (addr_pack),
    .addr_raw     (addr_raw),
    .addr_ext_raw (addr_ext_raw),
    .col_num      (col_num),
    .page_num     (page_num),
    .large_page   (large_page),
    .bus16        (bus16),
    .id_read      (id_read),
    .sector_mode  (sector_mode),
    .addr_word    (pk_word),
    .addr_ext     (pk_ext)
  );

  nseq_strobe #(.LOW(STROBE_LOW), .HIGH(STROBE_HIGH)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (st_go),
    .active   (st_active),
    .strobe_n (st_strobe_n),
    .sample   (st_sample),
    .done     (st_done)
  );

  nseq_ctrl #(
    .CNT_W(CNT_W), .WAIT_W(WAIT_W),
    .SECTOR_BYTES(SECTOR_BYTES), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .clr_end     (clr_end),
    .cmd_word    (cmd_word),
    .en_cmd1     (en_cmd1),
    .en_addr     (en_addr),
    .en_cmd2     (en_cmd2),
    .en_data     (en_data),
    .dir_write   (dir_write),
    .addr_cnt    (addr_cnt),
    .addr_word   (pk_word),
    .addr_ext    (pk_ext),
    .sector_mode (sector_mode),
    .sector_four (sector_four),
    .byte_count  (byte_count),
    .wait_limit  (wait_limit),
    .wr_data     (wr_data),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .busy        (busy),
    .end_flag    (end_flag),
    .timeout_err (timeout_err),
    .st_active   (st_active),
    .st_sample   (st_sample),
    .st_done     (st_done),
    .st_go       (st_go),
    .rd_phase    (rd_phase),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_io_out (nand_io_out),
    .nand_io_oe  (nand_io_oe),
    .nand_io_in  (nand_io_in),
    .nand_rb_n   (nand_rb_n)
  );

  assign nand_we_n = st_strobe_n | rd_phase;
  assign nand_re_n = st_strobe_n | !rd_phase;
endmodule

// File: rtl/nseq_checker.sv
module nseq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       end_flag,
  input logic       timeout_err,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_io_oe
);
  a_r10_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  a_r10_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);

  a_r14_rest_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe));

  a_r14_ce_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !nand_ce_n);

  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  a_r9_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_re_n) |-> !$past(rd_valid));

  a_r8_write_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nand_we_n) && !nand_cle && !nand_ale) |-> $past(wr_valid && wr_ready));

  a_r11_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> ($past(busy) && !busy));

  a_r12_timeout_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |=> end_flag);
endmodule

bind nand_phase_seq nseq_checker u_nseq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .end_flag    (end_flag),
  .timeout_err (timeout_err),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .rd_data     (rd_data),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .nand_ce_n   (nand_ce_n),
  .nand_cle    (nand_cle),
  .nand_ale    (nand_ale),
  .nand_we_n   (nand_we_n),
  .nand_re_n   (nand_re_n),
  .nand_io_oe  (nand_io_oe)
);

// File: tb/nand_phase_seq_test.sv
module nand_phase_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_CMD = 2'b10, K_ADR = 2'b01, K_DAT = 2'b00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, clr_end = 0;
  logic [15:0] cmd_word = 0;
  logic en_cmd1 = 0, en_addr = 0, en_cmd2 = 0, en_data = 0, dir_write = 0;
  logic [2:0] addr_cnt = 0;
  logic addr_pack = 0;
  logic [31:0] addr_raw = 0;
  logic [7:0] addr_ext_raw = 0;
  logic [11:0] col_num = 0;
  logic [23:0] page_num = 0;
  logic large_page = 0, bus16 = 0, id_read = 0, sector_mode = 0, sector_four = 0;
  logic [15:0] byte_count = 0, wait_limit = 16'd200;
  logic [7:0] wr_data = 0;
  logic wr_valid = 0, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, rd_ready = 1;
  logic busy, end_flag, timeout_err;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0] nand_io_out, nand_io_in;
  logic nand_rb_n = 1'b1;

  int n_chk = 0, n_bad = 0;
  int log_n = 0;
  logic [1:0] log_kind [32];
  logic [7:0] log_byte [32];
  int re_cnt = 0, rcount = 0;
  logic [7:0] rbuf [16];
  logic rb_auto = 1'b1;
  logic [7:0] rb_trig = 8'h30;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_phase_seq uut (.*);

  assign nand_io_in = 8'hA0 + re_cnt[7:0];

  // flash model: log bus cycles, run busy after the trigger command
  always @(posedge nand_we_n) begin
    if (nand_ce_n === 1'b0) begin
      if (log_n < 32) begin
        log_kind[log_n] = {nand_cle, nand_ale};
        log_byte[log_n] = nand_io_out;
      end
      log_n++;
      if (rb_auto && nand_cle && nand_io_out == rb_trig) fork
        begin
          repeat (3) @(negedge clk);
          nand_rb_n = 1'b0;
          repeat (10) @(negedge clk);
          nand_rb_n = 1'b1;
        end
      join_none
    end
  end

  always @(posedge nand_re_n) if (nand_ce_n === 1'b0) re_cnt++;

  always @(negedge clk) if (rst_n && rd_valid && rd_ready) begin
    if (rcount < 16) rbuf[rcount] = rd_data;
    rcount++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_log(input int i, input logic [1:0] k, input logic [7:0] b, input string req);
    logic [9:0] act;
    act = (i < log_n) ? {log_kind[i], log_byte[i]} : 10'h3FF;
    chk(act == {k, b}, req, 32'(act), 32'({k, b}));
  endtask

  task automatic defaults();
    @(negedge clk);
    cmd_word = 0; en_cmd1 = 0; en_addr = 0; en_cmd2 = 0; en_data = 0; dir_write = 0;
    addr_cnt = 0; addr_pack = 0; addr_raw = 0; addr_ext_raw = 0; col_num = 0; page_num = 0;
    large_page = 0; bus16 = 0; id_read = 0; sector_mode = 0; sector_four = 0;
    byte_count = 0; wait_limit = 16'd200; rd_ready = 1; wr_valid = 0; rb_auto = 1;
    log_n = 0; re_cnt = 0; rcount = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_end(input string req);
    int n = 0;
    while (!end_flag && n < 40000) begin @(negedge clk); n++; end
    chk(end_flag === 1'b1, req, 32'(end_flag), 1);
  endtask

  task automatic clear_end();
    @(negedge clk) clr_end = 1;
    @(negedge clk) clr_end = 0;
  endtask

  task automatic push_byte(input logic [7:0] b, input int gap);
    bit hs;
    repeat (gap) @(negedge clk);
    wr_valid = 1; wr_data = b;
    hs = 0;
    while (!hs) begin hs = wr_ready; @(negedge clk); end
    wr_valid = 0;
  endtask

  task automatic t_reset();
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe,
        "R14 rest pins", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe}, 6'b111000);
    chk(!busy && !end_flag && !timeout_err && !rd_valid, "R13 reset flags",
        {busy, end_flag, timeout_err, rd_valid}, 0);
  endtask

  task automatic t_large_read();
    defaults();
    cmd_word = 16'h3000; en_cmd1 = 1; en_addr = 1; en_cmd2 = 1; en_data = 1;
    addr_cnt = 5; addr_pack = 1; large_page = 1; col_num = 12'h123; page_num = 24'h0A0B0C;
    byte_count = 6; rb_trig = 8'h30; rd_ready = 0;
    pulse_start();
    @(negedge clk);
    chk(busy && !nand_ce_n, "R14 ce while busy", {busy, nand_ce_n}, 2'b10);
    while (!rd_valid) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(rd_valid && rd_data == 8'hA0 && re_cnt == 1, "R9 stall holds byte",
        {rd_valid, rd_data, 8'(re_cnt)}, {1'b1, 8'hA0, 8'd1});
    rd_ready = 1;
    wait_end("R11 read end");
    chk_log(0, K_CMD, 8'h00, "R2 first cmd");
    chk_log(1, K_ADR, 8'h23, "R4 col low");
    chk_log(2, K_ADR, 8'h01, "R4 col high");
    chk_log(3, K_ADR, 8'h0C, "R4 page b0");
    chk_log(4, K_ADR, 8'h0B, "R4 page b1");
    chk_log(5, K_ADR, 8'h0A, "R3 fifth byte ext");
    chk_log(6, K_CMD, 8'h30, "R1 cmd2 before read data");
    chk(log_n == 7, "R1 read log length", log_n, 7);
    chk(rcount == 6 && rbuf[0] == 8'hA0 && rbuf[5] == 8'hA5, "R9 read bytes",
        {8'(rcount), rbuf[0], rbuf[5]}, {8'd6, 8'hA0, 8'hA5});
    clear_end();
  endtask

  task automatic t_small_program();
    defaults();
    cmd_word = 16'h1080; en_cmd1 = 1; en_addr = 1; en_cmd2 = 1; en_data = 1; dir_write = 1;
    addr_cnt = 4; addr_pack = 1; bus16 = 1; col_num = 12'h1F4; page_num = 24'h123456;
    byte_count = 3; rb_trig = 8'h10;
    pulse_start();
    repeat (2) @(negedge clk);
    cmd_word = 16'hEEEE; page_num = 24'h999999;
    pulse_start();
    fork
      begin
        push_byte(8'h5C, 30);
        push_byte(8'h6D, 7);
        push_byte(8'h7E, 0);
      end
    join
    wait_end("R8 program end");
    chk_log(0, K_CMD, 8'h80, "R2 latched cmd1");
    chk_log(1, K_ADR, 8'hFA, "R6 halved column");
    chk_log(2, K_ADR, 8'h56, "R5 page b0");
    chk_log(3, K_ADR, 8'h34, "R5 page b1");
    chk_log(4, K_ADR, 8'h12, "R5 page b2");
    chk_log(5, K_DAT, 8'h5C, "R8 data 0");
    chk_log(6, K_DAT, 8'h6D, "R8 data 1");
    chk_log(7, K_DAT, 8'h7E, "R8 data 2");
    chk_log(8, K_CMD, 8'h10, "R1 cmd2 after write data");
    chk(log_n == 9, "R13 start ignored while busy", log_n, 9);
    clear_end();
  endtask

  task automatic t_id_read();
    defaults();
    cmd_word = 16'h0090; en_cmd1 = 1; en_addr = 1; en_data = 1;
    addr_cnt = 0; addr_pack = 1; bus16 = 1; id_read = 1; col_num = 12'h020; byte_count = 2;
    pulse_start();
    wait_end("R1 id end");
    chk_log(0, K_CMD, 8'h90, "R2 id cmd");
    chk_log(1, K_ADR, 8'h20, "R6 id column not halved");
    chk(log_n == 2, "R3 count zero gives one byte", log_n, 2);
    chk(rcount == 2 && rbuf[1] == 8'hA1, "R9 id bytes", {8'(rcount), rbuf[1]}, {8'd2, 8'hA1});
    clear_end();
  endtask

  task automatic t_sector(input bit four, input int exp_len);
    defaults();
    cmd_word = 16'h3000; en_cmd1 = 1; en_addr = 1; en_cmd2 = 1; en_data = 1;
    sector_mode = 1; sector_four = four; page_num = 24'h001234; addr_cnt = 3;
    byte_count = 5; rb_trig = 8'h30;
    pulse_start();
    wait_end("R7 sector end");
    chk_log(1, K_ADR, 8'hD0, "R7 page shifted b0");
    chk_log(2, K_ADR, 8'h48, "R7 page shifted b1");
    chk_log(3, K_ADR, 8'h00, "R7 page shifted b2");
    chk(rcount == exp_len && re_cnt == exp_len, "R7 sector length",
        {16'(rcount), 16'(re_cnt)}, {16'(exp_len), 16'(exp_len)});
    clear_end();
  endtask

  task automatic t_erase_wait();
    defaults();
    cmd_word = 16'hD060; en_cmd1 = 1; en_addr = 1; en_cmd2 = 1;
    addr_cnt = 7; addr_raw = 32'h00332211; addr_ext_raw = 8'h44; rb_trig = 8'hD0;
    pulse_start();
    while (nand_rb_n) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(busy && !end_flag, "R11 waits for ready", {busy, end_flag}, 2'b10);
    wait_end("R11 erase end");
    chk(!timeout_err, "R12 no timeout", timeout_err, 0);
    chk_log(1, K_ADR, 8'h11, "R3 raw b0");
    chk_log(4, K_ADR, 8'h00, "R3 raw b3");
    chk_log(5, K_ADR, 8'h44, "R3 count seven clamps to five");
    chk_log(6, K_CMD, 8'hD0, "R2 second cmd");
    chk(log_n == 7, "R3 erase log length", log_n, 7);
    clear_end();
  endtask

  task automatic t_timeout();
    defaults();
    cmd_word = 16'hD060; en_cmd1 = 1; en_cmd2 = 1; rb_auto = 0; wait_limit = 16'd20;
    pulse_start();
    wait_end("R12 timeout ends");
    chk(timeout_err === 1'b1, "R12 timeout flag", timeout_err, 1);
    repeat (5) @(negedge clk);
    chk(end_flag && timeout_err, "R13 flags persist", {end_flag, timeout_err}, 2'b11);
    clear_end();
    chk(!end_flag && !timeout_err, "R13 clear", {end_flag, timeout_err}, 0);
  endtask

  task automatic t_skip_phases();
    defaults();
    cmd_word = 16'h1180; en_addr = 1; en_data = 1; dir_write = 1;
    addr_cnt = 1; addr_raw = 32'h0000005A; byte_count = 1;
    pulse_start();
    push_byte(8'h77, 2);
    wait_end("R1 skip end");
    chk_log(0, K_ADR, 8'h5A, "R1 cmd1 skipped");
    chk_log(1, K_DAT, 8'h77, "R1 data after addr");
    chk(log_n == 2, "R1 cmd2 skipped", log_n, 2);
    clear_end();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_large_read();
    t_small_program();
    t_id_read();
    t_sector(1'b1, 2048);
    t_sector(1'b0, 512);
    t_erase_wait();
    t_timeout();
    t_skip_phases();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule